// File: doc/BRIEF.md
# FIFO Watermark DMA Request Generator

This block watches the fill level of a 32-bit data FIFO, 1024 words deep, placed between a card-side transfer engine and a host bus. In DMA mode it raises a burst request or a single-word request. In interrupt mode it raises a one-cycle threshold interrupt. Both cases depend on the direction of transfer, the programmed watermarks and whether the packet is ending. The FIFO storage, the DMA engine and the card protocol stay outside this block.

Receive (card to host) uses a "more than the watermark" test. Transmit (host to card) uses an "at most the watermark" test. When a packet ends, the block stops gating DMA requests on the watermark. It then drains or tops up the FIFO one word at a time, unless a command-completion timeout has aborted the receive. The block also decodes the burst-size code into a burst length and flags settings that are not allowed.

Top module: `wmark_dma_req`

## Requirements
- R1: After reset, and in the cycle after `soft_clr` is sampled high, `burst_req`, `single_req`, `rx_irq` and `tx_irq` are all 0.
- R2: `burst_len` follows `bsz_code` combinationally: 0→1, 1→4, 2→8, 3→16, 4→1, 5→1, 6→4, 7→8. Code 4 is reserved and sets `cfg_err`.
- R3: `cfg_err` is 1 when `rx_mark` exceeds 1022, when `tx_mark` is 0, or when `bsz_code` is 4. Otherwise it is 0. It is combinational.
- R4: In DMA receive mode (`dma_en`=1, `dir_tx`=0) without end of packet, `burst_req` rises one cycle after `fifo_cnt` > `rx_mark`. It does not rise when `fifo_cnt` equals `rx_mark`.
- R5: In DMA transmit mode (`dir_tx`=1) without end of packet, `burst_req` rises one cycle after `fifo_cnt` <= `tx_mark`. It does not rise when `fifo_cnt` is one above the mark.
- R6: A raised request holds while `dma_ack` is 0, even if the condition goes away. The cycle after `dma_ack` is sampled high, both requests are 0. The next cycle re-evaluates the condition against the current count.
- R7: In DMA receive mode with `eop`=1 and `ccs_tmo`=0, the watermark is ignored. `fifo_cnt` >= `burst_len` gives `burst_req`. A count of 1 to `burst_len`-1 gives `single_req`. A count of 0 gives no request.
- R8: In DMA receive mode with `ccs_tmo`=1, the end-of-packet flush is suppressed and `single_req` never rises. A watermark burst (`fifo_cnt` > `rx_mark`) is still raised.
- R9: In DMA transmit mode with `eop`=1, `single_req` is raised while `fifo_cnt` < 1024. No request is raised when the FIFO is full.
- R10: With `dma_en`=0, `dir_tx`=0 and `rx_irq_en`=1, `rx_irq` is a one-cycle pulse one cycle after `fifo_cnt` > `rx_mark` first becomes true. End of packet does not raise it below the mark. No DMA request is raised with `dma_en`=0.
- R11: With `dma_en`=0, `dir_tx`=1 and `tx_irq_en`=1, `tx_irq` is a one-cycle pulse one cycle after (`fifo_cnt` <= `tx_mark` or `eop`) first becomes true.
- R12: `burst_req` and `single_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of pending requests and interrupts |
| fifo_cnt | input | 13 | Current FIFO word count |
| dir_tx | input | 1 | 1 = transmit (host to card), 0 = receive |
| dma_en | input | 1 | 1 = DMA mode, 0 = interrupt mode |
| rx_irq_en | input | 1 | Receive threshold interrupt enable |
| tx_irq_en | input | 1 | Transmit threshold interrupt enable |
| eop | input | 1 | End-of-packet phase: less than one burst remains |
| ccs_tmo | input | 1 | Command-completion timeout seen |
| rx_mark | input | 12 | Receive watermark |
| tx_mark | input | 12 | Transmit watermark |
| bsz_code | input | 3 | Burst-size code |
| dma_ack | input | 1 | DMA engine accepts the pending request |
| burst_req | output | 1 | Burst DMA request |
| single_req | output | 1 | Single-word DMA request |
| rx_irq | output | 1 | Receive threshold interrupt pulse |
| tx_irq | output | 1 | Transmit threshold interrupt pulse |
| burst_len | output | 5 | Decoded burst length in words |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
`burst_len` and `cfg_err` are combinational, so the bench reads them in the same low clock phase in which it drives the configuration. Requests and interrupt pulses come from one register stage. Each input vector is driven on a falling edge, and its expected outputs enter a queue at that moment. The monitor takes them out just after the next rising edge, so each comparison lands exactly one cycle after its stimulus. Handshake sequences drive `dma_ack` in one vector and expect the drop in the following sample. The next vector then checks the re-evaluation.

// File: rtl/wmark_pkg.sv
package wmark_pkg;
   localparam int BLEN_W = 5;

   typedef enum logic [1:0] {
      REQ_IDLE   = 2'd0,
      REQ_BURST  = 2'd1,
      REQ_SINGLE = 2'd2
   } req_kind_e;
endpackage

// File: rtl/wmark_burst_dec.sv
module wmark_burst_dec
   import wmark_pkg::*;
(
   input  logic [2:0]        code,
   output logic [BLEN_W-1:0] blen,
   output logic              bad
);
   always_comb begin
      bad = 1'b0;
      unique case (code)
         3'd0:    blen = BLEN_W'(1);
         3'd1:    blen = BLEN_W'(4);
         3'd2:    blen = BLEN_W'(8);
         3'd3:    blen = BLEN_W'(16);
         3'd5:    blen = BLEN_W'(1);
         3'd6:    blen = BLEN_W'(4);
         3'd7:    blen = BLEN_W'(8);
         default: begin
            blen = BLEN_W'(1);
            bad  = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/wmark_thresh.sv
module wmark_thresh #(
   parameter int DEPTH  = 1024,
   parameter int CNT_W  = 13,
   parameter int MARK_W = 12
) (
   input  logic [CNT_W-1:0]  fifo_cnt,
   input  logic [MARK_W-1:0] rx_mark,
   input  logic [MARK_W-1:0] tx_mark,
   output logic              rx_hit,
   output logic              tx_hit,
   output logic              full,
   output logic              mark_bad
);
   localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
   localparam logic [MARK_W-1:0] RX_MAX   = MARK_W'(DEPTH - 2);

   logic [CNT_W-1:0] rx_ext, tx_ext;

   assign rx_ext   = {1'b0, rx_mark};
   assign tx_ext   = {1'b0, tx_mark};
   assign rx_hit   = fifo_cnt > rx_ext;
   assign tx_hit   = fifo_cnt <= tx_ext;
   assign full     = fifo_cnt >= FULL_CNT;
   assign mark_bad = (rx_mark > RX_MAX) || (tx_mark == '0);
endmodule

// File: rtl/wmark_req_ctl.sv
module wmark_req_ctl
   import wmark_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  req_kind_e want,
   input  logic      ack,
   output logic      burst_req,
   output logic      single_req
);
   req_kind_e kind_q, kind_d;

   always_comb begin
      if (clr)                    kind_d = REQ_IDLE;
      else if (kind_q != REQ_IDLE) kind_d = ack ? REQ_IDLE : kind_q;
      else                        kind_d = want;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kind_q <= REQ_IDLE;
      else        kind_q <= kind_d;
   end

   assign burst_req  = (kind_q == REQ_BURST);
   assign single_req = (kind_q == REQ_SINGLE);
endmodule

// File: rtl/wmark_irq_pulse.sv
module wmark_irq_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pulse  <= 1'b0;
      end else if (clr) begin
         prev_q <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         prev_q <= cond;
         pulse  <= cond & ~prev_q;
      end
   end
endmodule

// File: rtl/wmark_dma_req.sv
module wmark_dma_req
   import wmark_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int CNT_W  = 13,
   parameter int MARK_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic [CNT_W-1:0]  fifo_cnt,
   input  logic              dir_tx,
   input  logic              dma_en,
   input  logic              rx_irq_en,
   input  logic              tx_irq_en,
   input  logic              eop,
   input  logic              ccs_tmo,
   input  logic [MARK_W-1:0] rx_mark,
   input  logic [MARK_W-1:0] tx_mark,
   input  logic [2:0]        bsz_code,
   input  logic              dma_ack,
   output logic              burst_req,
   output logic              single_req,
   output logic              rx_irq,
   output logic              tx_irq,
   output logic [BLEN_W-1:0] burst_len,
   output logic              cfg_err
);
   localparam int N_IRQ = 2;

   if (MARK_W + 1 != CNT_W) begin : g_bad_width
      $error("count must be one bit wider than a watermark");
   end
   if (DEPTH > (1 << MARK_W)) begin : g_bad_depth
      $error("depth exceeds watermark range");
   end
   if (DEPTH < 16) begin : g_small_depth
      $error("depth below largest burst");
   end

   logic      rx_hit, tx_hit, full, mark_bad, code_bad;
   logic      have_burst, cnt_nz;
   req_kind_e want;
   logic [N_IRQ-1:0] irq_cond, irq_pulse;

   wmark_burst_dec u_dec (
      .code (bsz_code),
      .blen (burst_len),
      .bad  (code_bad)
   );

   wmark_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MARK_W(MARK_W)) u_thr (
      .fifo_cnt (fifo_cnt),
      .rx_mark  (rx_mark),
      .tx_mark  (tx_mark),
      .rx_hit   (rx_hit),
      .tx_hit   (tx_hit),
      .full     (full),
      .mark_bad (mark_bad)
   );

   assign cfg_err    = mark_bad | code_bad;
   assign have_burst = fifo_cnt >= CNT_W'(burst_len);
   assign cnt_nz     = fifo_cnt != '0;

   always_comb begin
      want = REQ_IDLE;
      if (dma_en) begin
         if (!dir_tx) begin
            if (eop && !ccs_tmo) begin
               if (have_burst)  want = REQ_BURST;
               else if (cnt_nz) want = REQ_SINGLE;
            end else if (rx_hit) begin
               want = REQ_BURST;
            end
         end else begin
            if (eop) begin
               if (!full) want = REQ_SINGLE;
            end else if (tx_hit) begin
               want = REQ_BURST;
            end
         end
      end
   end

   wmark_req_ctl u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_clr | ~dma_en),
      .want       (want),
      .ack        (dma_ack),
      .burst_req  (burst_req),
      .single_req (single_req)
   );

   assign irq_cond[0] = ~dma_en & ~dir_tx & rx_irq_en & rx_hit;
   assign irq_cond[1] = ~dma_en &  dir_tx & tx_irq_en & (tx_hit | eop);

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      wmark_irq_pulse u_pulse (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (soft_clr),
         .cond  (irq_cond[i]),
         .pulse (irq_pulse[i])
      );
   end

   assign rx_irq = irq_pulse[0];
   assign tx_irq = irq_pulse[1];
endmodule

// File: rtl/wmark_chk.sv
module wmark_chk #(
   parameter int CNT_W  = 13,
   parameter int MARK_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_clr,
   input logic              dir_tx,
   input logic              dma_en,
   input logic              rx_irq_en,
   input logic              ccs_tmo,
   input logic              dma_ack,
   input logic              burst_req,
   input logic              single_req,
   input logic              rx_irq,
   input logic              tx_irq
);
   // R12
   a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({burst_req, single_req}));

   // R1
   a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> !burst_req && !single_req && !rx_irq && !tx_irq);

   // R6
   a_r6_hold_burst: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req && !dma_ack && !soft_clr && dma_en |=> burst_req);

   a_r6_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
      single_req && !dma_ack && !soft_clr && dma_en |=> single_req);

   a_r6_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_req || single_req) && dma_ack |=> !burst_req && !single_req);

   // R8
   a_r8_no_flush_after_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_req && !single_req && dma_en && !dir_tx && ccs_tmo |=> !single_req);

   // R10
   a_r10_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   a_r10_rx_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(!dma_en && rx_irq_en && !dir_tx));

   // R11
   a_r11_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   a_r11_tx_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(!dma_en && dir_tx));
endmodule

bind wmark_dma_req wmark_chk #(.CNT_W(CNT_W), .MARK_W(MARK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_clr   (soft_clr),
   .dir_tx     (dir_tx),
   .dma_en     (dma_en),
   .rx_irq_en  (rx_irq_en),
   .ccs_tmo    (ccs_tmo),
   .dma_ack    (dma_ack),
   .burst_req  (burst_req),
   .single_req (single_req),
   .rx_irq     (rx_irq),
   .tx_irq     (tx_irq)
);

// File: tb/wmark_dma_req_tb.sv
module wmark_dma_req_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 200000;

   logic        clk = 1'b0;
   logic        rst_n, soft_clr, dir_tx, dma_en, rx_irq_en, tx_irq_en;
   logic        eop, ccs_tmo, dma_ack;
   logic [12:0] fifo_cnt;
   logic [11:0] rx_mark, tx_mark;
   logic [2:0]  bsz_code;
   logic        burst_req, single_req, rx_irq, tx_irq, cfg_err;
   logic [4:0]  burst_len;

   // shadow settings copied onto the inputs at each falling edge
   logic        s_rst_n = 1'b0, s_clr = 1'b0, s_tx = 1'b0, s_dma = 1'b0;
   logic        s_rxie = 1'b0, s_txie = 1'b0, s_tmo = 1'b0;
   logic [11:0] s_rxm = 12'd511, s_txm = 12'd512;
   logic [2:0]  s_code = 3'd0;

   typedef struct {
      logic  b, s, ri, ti;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_err = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wmark_dma_req u_dut (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .fifo_cnt(fifo_cnt),
      .dir_tx(dir_tx), .dma_en(dma_en), .rx_irq_en(rx_irq_en),
      .tx_irq_en(tx_irq_en), .eop(eop), .ccs_tmo(ccs_tmo),
      .rx_mark(rx_mark), .tx_mark(tx_mark), .bsz_code(bsz_code),
      .dma_ack(dma_ack), .burst_req(burst_req), .single_req(single_req),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .burst_len(burst_len),
      .cfg_err(cfg_err)
   );

   task automatic step(input int cnt, input bit e, input bit ack,
                       input bit b, input bit s, input bit ri, input bit ti,
                       input string tag);
      exp_t x;
      @(negedge clk);
      rst_n = s_rst_n; soft_clr = s_clr; dir_tx = s_tx; dma_en = s_dma;
      rx_irq_en = s_rxie; tx_irq_en = s_txie; ccs_tmo = s_tmo;
      rx_mark = s_rxm; tx_mark = s_txm; bsz_code = s_code;
      fifo_cnt = 13'(cnt); eop = e; dma_ack = ack;
      x.b = b; x.s = s; x.ri = ri; x.ti = ti; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic chk_comb(input logic [4:0] exp_len, input bit exp_err,
                           input string tag);
      #1;
      n_chk++;
      if (burst_len !== exp_len || cfg_err !== exp_err) begin
         n_err++;
         $display("FAIL %s: len=%0d err=%b expected len=%0d err=%b",
                  tag, burst_len, cfg_err, exp_len, exp_err);
      end
   endtask

   function automatic logic [4:0] len_of(input int c);
      case (c)
         1: return 5'd4;  2: return 5'd8;  3: return 5'd16;
         6: return 5'd4;  7: return 5'd8;
         default: return 5'd1;
      endcase
   endfunction

   // monitor: scoreboard pop one cycle after each driven vector
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_chk++;
            if ({burst_req, single_req, rx_irq, tx_irq} !== {x.b, x.s, x.ri, x.ti}) begin
               n_err++;
               $display("FAIL %s: b/s/ri/ti=%b%b%b%b expected %b%b%b%b", x.tag,
                        burst_req, single_req, rx_irq, tx_irq, x.b, x.s, x.ri, x.ti);
            end
            n_chk++;
            if (burst_req && single_req) begin
               n_err++;
               $display("FAIL R12: both requests=1 expected at most one");
            end
         end
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run not finished expected finish");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; soft_clr = 0; dir_tx = 0; dma_en = 0; rx_irq_en = 0;
      tx_irq_en = 0; eop = 0; ccs_tmo = 0; dma_ack = 0; fifo_cnt = '0;
      rx_mark = 12'd511; tx_mark = 12'd512; bsz_code = 3'd0;

      // R1 reset state
      step(0, 0, 0, 0, 0, 0, 0, "R1 in reset");
      step(0, 0, 0, 0, 0, 0, 0, "R1 in reset");
      s_rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0, 0, "R1 after reset");

      // R2 burst length decode
      for (int c = 0; c < 8; c++) begin
         s_code = 3'(c);
         step(0, 0, 0, 0, 0, 0, 0, "R2 idle");
         chk_comb(len_of(c), c == 4, "R2 decode");
      end
      s_code = 3'd2;

      // R3 watermark legality
      s_rxm = 12'd1022;
      step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
      chk_comb(5'd8, 1'b0, "R3 rx 1022 legal");
      s_rxm = 12'd1023;
      step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
      chk_comb(5'd8, 1'b1, "R3 rx 1023 illegal");
      s_rxm = 12'd100; s_txm = 12'd0;
      step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
      chk_comb(5'd8, 1'b1, "R3 tx 0 illegal");
      s_txm = 12'd1;
      step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
      chk_comb(5'd8, 1'b0, "R3 tx 1 legal");

      // R4 receive watermark, R6 handshake
      s_dma = 1; s_tx = 0; s_txm = 12'd64;
      step(100, 0, 0, 0, 0, 0, 0, "R4 at mark");
      step(101, 0, 0, 1, 0, 0, 0, "R4 above mark");
      step(50,  0, 0, 1, 0, 0, 0, "R6 held without ack");
      step(50,  0, 1, 0, 0, 0, 0, "R6 drop after ack");
      step(50,  0, 0, 0, 0, 0, 0, "R6 re-eval below");
      step(200, 0, 0, 1, 0, 0, 0, "R6 re-eval above");
      step(200, 0, 1, 0, 0, 0, 0, "R6 drop after ack");
      step(200, 0, 0, 1, 0, 0, 0, "R6 re-raise");
      step(200, 0, 1, 0, 0, 0, 0, "R6 drop after ack");

      // R5 transmit watermark
      s_tx = 1;
      step(65,  0, 0, 0, 0, 0, 0, "R5 one above mark");
      step(64,  0, 0, 1, 0, 0, 0, "R5 at mark");
      step(500, 0, 1, 0, 0, 0, 0, "R6 tx drop after ack");
      step(500, 0, 0, 0, 0, 0, 0, "R5 re-eval above mark");

      // R9 transmit end of packet
      step(1024, 1, 0, 0, 0, 0, 0, "R9 full fifo");
      step(1000, 1, 0, 0, 1, 0, 0, "R9 single while not full");
      step(1000, 1, 1, 0, 0, 0, 0, "R9 drop after ack");
      step(1000, 0, 0, 0, 0, 0, 0, "R9 eop over");

      // R7 receive flush
      s_tx = 0; s_code = 3'd3;
      step(20, 1, 0, 1, 0, 0, 0, "R7 burst below mark");
      step(20, 1, 1, 0, 0, 0, 0, "R7 drop after ack");
      step(5,  1, 0, 0, 1, 0, 0, "R7 single flush");
      step(5,  1, 1, 0, 0, 0, 0, "R7 drop after ack");
      step(0,  1, 0, 0, 0, 0, 0, "R7 empty no request");

      // R8 timeout suppresses flush
      s_tmo = 1;
      step(5,   1, 0, 0, 0, 0, 0, "R8 no single flush");
      step(20,  1, 0, 0, 0, 0, 0, "R8 no threshold-free burst");
      step(101, 1, 0, 1, 0, 0, 0, "R8 watermark burst kept");
      step(101, 1, 1, 0, 0, 0, 0, "R8 drop after ack");
      s_tmo = 0;

      // R1 soft clear
      step(200, 0, 0, 1, 0, 0, 0, "R1 setup burst");
      s_clr = 1;
      step(200, 0, 0, 0, 0, 0, 0, "R1 soft clear");
      s_clr = 0;
      step(200, 0, 0, 1, 0, 0, 0, "R1 after clear");
      step(200, 0, 1, 0, 0, 0, 0, "R1 drop after ack");

      // R10 receive interrupt
      s_dma = 0; s_rxie = 1;
      step(50,  0, 0, 0, 0, 0, 0, "R10 below mark");
      step(101, 0, 0, 0, 0, 1, 0, "R10 pulse");
      step(101, 0, 0, 0, 0, 0, 0, "R10 single cycle");
      step(50,  0, 0, 0, 0, 0, 0, "R10 below mark");
      step(50,  1, 0, 0, 0, 0, 0, "R10 eop below mark");
      s_rxie = 0;
      step(200, 0, 0, 0, 0, 0, 0, "R10 disabled");
      s_rxie = 1;
      step(200, 0, 0, 0, 0, 1, 0, "R10 enable rise");

      // R11 transmit interrupt
      s_rxie = 0; s_tx = 1; s_txie = 1;
      step(500, 0, 0, 0, 0, 0, 0, "R11 above mark");
      step(500, 1, 0, 0, 0, 0, 1, "R11 eop pulse");
      step(500, 1, 0, 0, 0, 0, 0, "R11 single cycle");
      step(500, 0, 0, 0, 0, 0, 0, "R11 eop gone");
      step(30,  0, 0, 0, 0, 0, 1, "R11 at or below mark");
      step(30,  0, 0, 0, 0, 0, 0, "R11 single cycle");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule